// File: doc/BRIEF.md
# Manchester Line Encoder with Rising-Edge Tail

This block turns a serial NRZ transmit stream into a single Manchester-coded line bit for a 10 Mb/s twisted-pair driver. A local divider splits every bit cell into two half-cell slots of `HALF_DIV` system clocks each. The block drives a bit-rate clock, `tx_clk`, out to the data source. That clock rises at the start of every cell. At each rising edge the block samples the enable and data inputs and starts the matching cell on the line in the same clock cycle. A source that changes its inputs after a rising edge of `tx_clk` therefore has them taken at the next one.

When the enable is sampled low after a frame, the block closes the frame in a fixed way. The line is driven high at that cell boundary, so the last transition is always rising. That transition sits at mid-cell of the final one (the data already rose there) or at the end of a final zero. The line then stays high for `TAIL_BITS` cell times and drops to the idle low level. The `active` flag falls in the same cycle. The enable is not looked at while this tail runs.

Top module: `mcx_encoder`

## Requirements
- R1: Synchronous active-high reset drives `line_out`, `active` and `tx_clk` low.
- R2: While no frame or tail is in progress, `line_out` and `active` stay low.
- R3: A data one is sent as low in the first half-cell and high in the second. A data zero is sent as high, then low. Each half lasts exactly `HALF_DIV` clock cycles.
- R4: `tx_en` and `tx_bit` are sampled only at the clock edge on which `tx_clk` rises. The line takes the first half of the sampled cell on that same edge.
- R5: A frame starts at the first cell boundary where `tx_en` is sampled high, and `active` rises together with the first half-cell.
- R6: At the first cell boundary where `tx_en` is sampled low during a frame, `line_out` is driven high. The last line transition of the frame is therefore rising: mid-cell for a final one, end of cell for a final zero.
- R7: After that boundary `line_out` stays high for exactly `TAIL_BITS` cell times, then goes low with `active` falling on the same edge.
- R8: `tx_en` and `tx_bit` have no effect during the tail, including the boundary at which the tail ends. A new frame can start at the boundary after that one.
- R9: Every data cell has a line transition at its middle.
- R10: `tx_clk` is high for the first half of each cell and low for the second, with a period of `2*HALF_DIV` clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable, sampled at each cell start |
| tx_bit | input | 1 | Serial NRZ data bit, sampled at each cell start |
| tx_clk | output | 1 | Bit-rate clock; rises at each cell start |
| line_out | output | 1 | Manchester-coded line level |
| active | output | 1 | High from the first data cell until the tail ends |

## Verification
The bench builds the block with `HALF_DIV = 3` and `TAIL_BITS = 2`. An odd, non-unity divider checks that every half-cell lasts exactly three cycles and that `tx_clk` lines up with the line updates. A two-cell tail runs long enough that enable pulses can land both inside it and on its closing boundary. Random enable bursts with random data give single-bit frames, back-to-back frames and frames ending in either value. Directed sequences pin down the tail for each final bit and the first start after the tail.

// File: rtl/mcx_pkg.sv
package mcx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_TAIL = 2'd2
  } mcx_state_e;

  // Level of the first half-cell: a one starts low, a zero starts high.
  function automatic logic lead_level(input logic b);
    return ~b;
  endfunction

  // Level of the second half-cell.
  function automatic logic trail_level(input logic b);
    return b;
  endfunction

endpackage

// File: rtl/mcx_half_timer.sv
module mcx_half_timer #(
  parameter int HALF_DIV = 3
) (
  input  logic clk,
  input  logic rst,
  output logic cell_start,
  output logic cell_mid,
  output logic tx_clk
);

  logic half_tick;
  logic phase_q;
  logic tx_clk_q;

  generate
    if (HALF_DIV <= 1) begin : g_every_cycle
      assign half_tick = 1'b1;
    end else begin : g_divider
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (cnt_q == CW'(HALF_DIV - 1)) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      assign half_tick = (cnt_q == CW'(HALF_DIV - 1));
    end
  endgenerate

  // phase_q = 0 while the first half of a cell runs, 1 during the second
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= 1'b0;
      tx_clk_q <= 1'b0;
    end else if (half_tick) begin
      phase_q  <= ~phase_q;
      tx_clk_q <= phase_q;
    end
  end

  assign cell_start = half_tick & phase_q;
  assign cell_mid   = half_tick & ~phase_q;
  assign tx_clk     = tx_clk_q;

  // R10: a cell start is followed by tx_clk high
  assert_txclk_high_R10: assert property (@(posedge clk) disable iff (rst)
    cell_start |=> tx_clk)
    else $error("tx_clk not high after cell start");

  // R10: a mid-cell tick is followed by tx_clk low
  assert_txclk_low_R10: assert property (@(posedge clk) disable iff (rst)
    cell_mid |=> !tx_clk)
    else $error("tx_clk not low after mid-cell");

endmodule

// File: rtl/mcx_tail_counter.sv
module mcx_tail_counter #(
  parameter int TAIL_BITS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic step,
  output logic done
);

  localparam int SLOTS = 2 * TAIL_BITS;
  localparam int TW    = (SLOTS > 2) ? $clog2(SLOTS) : 1;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= TW'(SLOTS - 1);
    end else if (step && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // R7: a freshly loaded tail is never reported finished on the next cycle
  assert_tail_not_done_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> !done)
    else $error("tail finished right after load");

endmodule

// File: rtl/mcx_frame_ctrl.sv
module mcx_frame_ctrl
  import mcx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cell_start,
  input  logic cell_mid,
  input  logic tx_en,
  input  logic tx_bit,
  input  logic tail_done,
  output logic tail_load,
  output logic tail_step,
  output logic line_out,
  output logic active
);

  mcx_state_e st_q;
  logic       bit_q;
  logic       line_q;
  logic       act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      bit_q  <= 1'b0;
      line_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (cell_start && tx_en) begin
            st_q   <= ST_DATA;
            bit_q  <= tx_bit;
            line_q <= lead_level(tx_bit);
            act_q  <= 1'b1;
          end
        end
        ST_DATA: begin
          if (cell_start) begin
            if (tx_en) begin
              bit_q  <= tx_bit;
              line_q <= lead_level(tx_bit);
            end else begin
              st_q   <= ST_TAIL;
              line_q <= 1'b1;
            end
          end else if (cell_mid) begin
            line_q <= trail_level(bit_q);
          end
        end
        ST_TAIL: begin
          if (cell_start && tail_done) begin
            st_q   <= ST_IDLE;
            line_q <= 1'b0;
            act_q  <= 1'b0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign tail_load = (st_q == ST_DATA) && cell_start && !tx_en;
  assign tail_step = (st_q == ST_TAIL) && (cell_start || cell_mid);
  assign line_out  = line_q;
  assign active    = act_q;

  // R2: the line is low whenever no frame or tail is running
  assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> !line_q)
    else $error("line high while inactive");

  // R5: the first half-cell carries the inverse of the sampled bit
  assert_start_level_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(act_q) |-> (line_q == !$past(tx_bit)))
    else $error("wrong first half at frame start");

  // R9: each data cell toggles the line at its middle
  assert_mid_transition_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DATA && cell_mid) |=> (line_q != $past(line_q)))
    else $error("no mid-cell transition");

  // R7: the line is held high throughout the tail
  assert_tail_high_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TAIL) |-> line_q)
    else $error("line low during tail");

  // R7: active drops on the same edge as the line returns low
  assert_end_together_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(act_q) |-> $fell(line_q))
    else $error("active fell without line falling");

  // R8: enable pulses cannot cut the tail short
  assert_tail_ignores_en_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TAIL && !tail_done) |=> (st_q == ST_TAIL))
    else $error("tail left early");

endmodule

// File: rtl/mcx_encoder.sv
module mcx_encoder #(
  parameter int HALF_DIV  = 3,
  parameter int TAIL_BITS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic tx_bit,
  output logic tx_clk,
  output logic line_out,
  output logic active
);

  logic cell_start;
  logic cell_mid;
  logic tail_load;
  logic tail_step;
  logic tail_done;

  mcx_half_timer #(
    .HALF_DIV(HALF_DIV)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .cell_start(cell_start),
    .cell_mid  (cell_mid),
    .tx_clk    (tx_clk)
  );

  mcx_tail_counter #(
    .TAIL_BITS(TAIL_BITS)
  ) u_tail (
    .clk (clk),
    .rst (rst),
    .load(tail_load),
    .step(tail_step),
    .done(tail_done)
  );

  mcx_frame_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cell_start(cell_start),
    .cell_mid  (cell_mid),
    .tx_en     (tx_en),
    .tx_bit    (tx_bit),
    .tail_done (tail_done),
    .tail_load (tail_load),
    .tail_step (tail_step),
    .line_out  (line_out),
    .active    (active)
  );

endmodule

// File: tb/tb_mcx_encoder.sv
module tb_mcx_encoder;

  localparam int HALF_DIV  = 3;
  localparam int TAIL_BITS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0;
  logic tx_bit = 1'b0;
  logic tx_clk, line_out, active;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mcx_encoder #(.HALF_DIV(HALF_DIV), .TAIL_BITS(TAIL_BITS)) dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tx_bit(tx_bit),
    .tx_clk(tx_clk), .line_out(line_out), .active(active)
  );

  // Bench model state: 0 idle, 1 data, 2 tail
  int  m_state = 0;
  int  m_tail = 0;
  int  ncount = 0;
  int  last_rise = -1;
  logic prev_tclk = 1'b0;
  logic hold_line = 1'b0;
  logic hold_act = 1'b0;

  task automatic check(input logic ok, input string tag, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic step_neg();
    @(negedge clk);
    ncount++;
  endtask

  // Expected levels of one cell given the inputs sampled at its start
  task automatic model_cell(input logic en, input logic b,
                            output logic first, output logic second,
                            output logic act, output string tag);
    case (m_state)
      0: begin
        if (en) begin
          m_state = 1; first = ~b; second = b; act = 1'b1; tag = "R5";
        end else begin
          first = 1'b0; second = 1'b0; act = 1'b0; tag = "R2";
        end
      end
      1: begin
        if (en) begin
          first = ~b; second = b; act = 1'b1; tag = "R3";
        end else begin
          m_state = 2; m_tail = TAIL_BITS - 1;
          first = 1'b1; second = 1'b1; act = 1'b1; tag = "R6";
        end
      end
      default: begin
        if (m_tail > 0) begin
          m_tail--; first = 1'b1; second = 1'b1; act = 1'b1;
          tag = en ? "R8" : "R7";
        end else begin
          m_state = 0; first = 1'b0; second = 1'b0; act = 1'b0;
          tag = en ? "R8" : "R7";
        end
      end
    endcase
  endtask

  // Present inputs for the next cell, then check that cell in full
  task automatic send_cell(input logic en, input logic b);
    logic first, second, act;
    string tag;
    int waited = 0;
    bit rise = 1'b0;
    tx_en = en;
    tx_bit = b;
    while (!rise && waited < 4 * HALF_DIV + 4) begin
      step_neg();
      waited++;
      rise = tx_clk && !prev_tclk;
      prev_tclk = tx_clk;
      if (!rise) begin
        // remainder of the previous cell's second half (R3, R4)
        check(line_out == hold_line, "R4", line_out, hold_line);
        check(active == hold_act, "R4", active, hold_act);
      end
    end
    if (!rise) begin
      check(1'b0, "R10", 0, 1);
      return;
    end
    if (last_rise >= 0)
      check(ncount - last_rise == 2 * HALF_DIV, "R10", ncount - last_rise, 2 * HALF_DIV);
    last_rise = ncount;
    model_cell(en, b, first, second, act, tag);
    // inputs may change now without affecting this cell (R4)
    tx_bit = ~b;
    tx_en = $urandom_range(0, 1);
    check(line_out == first, tag, line_out, first);
    check(active == act, tag, active, act);
    for (int i = 1; i < HALF_DIV; i++) begin
      step_neg();
      prev_tclk = tx_clk;
      check(line_out == first, "R3", line_out, first);
    end
    step_neg();
    prev_tclk = tx_clk;
    check(line_out == second, tag, line_out, second);
    check(tx_clk == 1'b0, "R10", tx_clk, 0);
    if (m_state == 1)
      check(line_out != first, "R9", line_out, !first);
    hold_line = second;
    hold_act = act;
  endtask

  task automatic send_frame(input logic [15:0] bits, input int len);
    for (int i = 0; i < len; i++) send_cell(1'b1, bits[i]);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(line_out == 1'b0, "R1", line_out, 0);
    check(active == 1'b0, "R1", active, 0);
    check(tx_clk == 1'b0, "R1", tx_clk, 0);
    rst = 1'b0;

    // idle cells
    send_cell(1'b0, 1'b1);
    send_cell(1'b0, 1'b0);
    // single-bit frame ending in one, then tail (R6, R7)
    send_frame(16'h0001, 1);
    repeat (4) send_cell(1'b0, 1'b0);
    // single-bit frame ending in zero
    send_frame(16'h0000, 1);
    repeat (4) send_cell(1'b0, 1'b1);
    // enable raised during the tail and on its closing boundary (R8)
    send_frame(16'h000D, 4);
    send_cell(1'b0, 1'b0);
    send_cell(1'b1, 1'b1);
    send_cell(1'b1, 1'b0);
    // starts right after the tail
    send_frame(16'h0005, 3);
    repeat (4) send_cell(1'b0, 1'b0);

    // random enable bursts with random data
    for (int f = 0; f < 150; f++) begin
      int len;
      len = $urandom_range(1, 10);
      for (int i = 0; i < len; i++) send_cell(1'b1, 1'($urandom_range(0, 1)));
      len = $urandom_range(0, 4);
      for (int i = 0; i < len; i++) send_cell(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      len = $urandom_range(0, 3);
      for (int i = 0; i < len; i++) send_cell(1'b0, 1'($urandom_range(0, 1)));
    end
    repeat (4) send_cell(1'b0, 1'b0);
    check(active == 1'b0, "R2", active, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule